// File: doc/BRIEF.md
# Three-Register Single-Cycle Datapath

This block is a small clocked execution engine. Each clock it takes one 19-bit instruction from an external instruction source, reads two operands from an internal bank of 32 eight-bit registers, and passes them through an arithmetic/logic unit. On the rising edge it stores the result back into a third register, chosen by the instruction, and moves the program counter forward by one. The instruction source uses the program counter output to present the next word. The carry out of the arithmetic is stored in a separate one-bit status register and is not written into the register bank.

Before execution begins, the surrounding logic preloads the register bank through a load port. While the load enable is high, the external write takes the single write port, the program counter and status bit hold, and the instruction on the bus is neither executed nor written back. The combinational result bus is brought out, so the value the current instruction would store can be seen before the edge.

Top module: `reg3_exec`

## Requirements
- R1: Instruction fields are fixed, with no decode stage: bits 18:16 are the operation code, bit 15 the carry-in, bits 14:10 the first source register, bits 9:5 the second source register and bits 4:0 the destination register.
- R2: Operation codes: 0 stores A AND B, 1 stores A OR B, 2 stores NOT A, 3 stores A + B + carry-in, 4 stores A − B (computed as A + ~B + 1, with the instruction carry-in ignored). The result is written to the destination register on the rising edge.
- R3: After an executed instruction, `carryFlag` holds the adder carry out for codes 3 and 4 (for code 4 it is 1 exactly when A ≥ B unsigned) and 0 for codes 0, 1 and 2.
- R4: Codes 5, 6 and 7 put 0 on `yBus`, write 0 to the destination register and clear `carryFlag`.
- R5: `pc` rises by one on every clock edge on which an instruction executes and wraps from 255 to 0.
- R6: While `loadEn` is high, `loadData` is written to register `loadAddr`, `pc` and `carryFlag` hold, and the instruction on `instr` writes nothing.
- R7: Register reads are combinational: `yBus` shows, before the edge, the result computed from the register contents as they stand, so a register being written in the same cycle is read with its old value.
- R8: A synchronous, active-high `rst` clears `pc`, `carryFlag` and all 32 registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state captures on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | External register load enable; suspends execution |
| loadAddr | input | 5 | Register written by the external load |
| loadData | input | 8 | Value written by the external load |
| instr | input | 19 | Current instruction word |
| pc | output | 8 | Program counter addressing the instruction source |
| carryFlag | output | 1 | Status register holding the last carry out |
| yBus | output | 8 | Combinational ALU result for the current instruction |

## Verification
The bench targets a carry chain that wraps (0xFF + 0x01 with and without carry-in) and a subtraction that must ignore the instruction carry-in: a design that passes the carry-in through, or takes the carry from the wrong position, gives an off-by-one sum or the wrong status bit. Instructions whose destination is also a source check that the read happens before the write. A design that forwards the new value would show the new data on `yBus` too early. Loads are applied while an instruction that would write a register sits on the bus, and that register is read afterwards. This exposes a design that executes during load, advances `pc` or changes `carryFlag`. Undefined codes, `pc` wrap at 255 and reset in the middle of a run are also covered: a design that leaves stale data, does not wrap `pc`, or keeps the flag through reset is reported.

// File: rtl/regdp_pkg.sv
package regdp_pkg;

  // Width of the operation field; fixed by the instruction layout.
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NOT  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_RSV5 = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } aluOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic rfWrite;     // register bank write port active
    logic rfFromLoad;  // write port fed by the external load
    logic flagWrite;   // status bit captures the ALU carry
    logic pcAdvance;   // program counter steps
  } ctrlStrobe_t;

endpackage

// File: rtl/regdp_regfile.sv
module regdp_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  // Combinational reads: same-cycle write is seen only after the edge.
  assign rdDataA = mem[rdAddrA];
  assign rdDataB = mem[rdAddrB];

  // R2 / R6: a write lands in the addressed entry.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> mem[$past(wrAddr)] == $past(wrData));

endmodule

// File: rtl/regdp_alu.sv
module regdp_alu
  import regdp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit ISOLATE = 1'b1
) (
  input  aluOp_e            opSel,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  logic isArith, isLogic, invertB;
  logic [DATA_W-1:0] arithA, arithB, logicA, logicB, bEff;
  logic [DATA_W-1:0] andBits, orBits, notBits, sumBits;
  logic [DATA_W:0]   chain;

  assign isArith = (opSel == OP_ADD) || (opSel == OP_SUB);
  assign isLogic = (opSel == OP_AND) || (opSel == OP_OR) || (opSel == OP_NOT);
  assign invertB = (opSel == OP_SUB);

  // Operand steering: unused clusters see constant zero when isolated.
  generate
    if (ISOLATE) begin : g_iso
      assign arithA = isArith ? opA : '0;
      assign arithB = isArith ? opB : '0;
      assign logicA = isLogic ? opA : '0;
      assign logicB = isLogic ? opB : '0;
    end else begin : g_open
      assign arithA = opA;
      assign arithB = opB;
      assign logicA = opA;
      assign logicB = opB;
    end
  endgenerate

  assign bEff     = invertB ? ~arithB : arithB;
  assign chain[0] = invertB ? 1'b1 : carryIn;

  // One slice per bit: logic gates plus a full adder of the ripple chain.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign andBits[i]  = logicA[i] & logicB[i];
      assign orBits[i]   = logicA[i] | logicB[i];
      assign notBits[i]  = ~logicA[i];
      assign sumBits[i]  = arithA[i] ^ bEff[i] ^ chain[i];
      assign chain[i+1]  = (arithA[i] & bEff[i]) | (chain[i] & (arithA[i] ^ bEff[i]));
    end
  endgenerate

  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    case (opSel)
      OP_AND: result = andBits;
      OP_OR:  result = orBits;
      OP_NOT: result = notBits;
      OP_ADD, OP_SUB: begin
        result   = sumBits;
        carryOut = chain[DATA_W];
      end
      default: begin
        result   = '0;
        carryOut = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/regdp_ctrl.sv
module regdp_ctrl
  import regdp_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int INSTR_W = OP_W + 1 + 3 * ADDR_W
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               loadEn,
  output aluOp_e             opSel,
  output logic               carryIn,
  output logic [ADDR_W-1:0]  srcA,
  output logic [ADDR_W-1:0]  srcB,
  output logic [ADDR_W-1:0]  dst,
  output ctrlStrobe_t        strobe
);

  localparam int DST_LO  = 0;
  localparam int SRCB_LO = ADDR_W;
  localparam int SRCA_LO = 2 * ADDR_W;
  localparam int CIN_POS = 3 * ADDR_W;
  localparam int OP_LO   = 3 * ADDR_W + 1;

  // Fields drive the datapath directly.
  assign opSel   = aluOp_e'(instr[OP_LO +: OP_W]);
  assign carryIn = instr[CIN_POS];
  assign srcA    = instr[SRCA_LO +: ADDR_W];
  assign srcB    = instr[SRCB_LO +: ADDR_W];
  assign dst     = instr[DST_LO  +: ADDR_W];

  // The load owns the write port and freezes execution.
  assign strobe.rfWrite    = 1'b1;
  assign strobe.rfFromLoad = loadEn;
  assign strobe.flagWrite  = ~loadEn;
  assign strobe.pcAdvance  = ~loadEn;

endmodule

// File: rtl/regdp_dp.sv
module regdp_dp
  import regdp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int PC_W    = 8,
  parameter bit ISOLATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  aluOp_e            opSel,
  input  logic              carryIn,
  input  logic [ADDR_W-1:0] srcA,
  input  logic [ADDR_W-1:0] srcB,
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic [PC_W-1:0]   pc,
  output logic              carryFlag,
  output logic [DATA_W-1:0] yBus
);

  logic [DATA_W-1:0] rdA, rdB, wrData;
  logic [ADDR_W-1:0] wrAddr;
  logic              aluCarry;

  assign wrAddr = strobe.rfFromLoad ? loadAddr : dst;
  assign wrData = strobe.rfFromLoad ? loadData : yBus;

  regdp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (strobe.rfWrite),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddrA (srcA),
    .rdAddrB (srcB),
    .rdDataA (rdA),
    .rdDataB (rdB)
  );

  regdp_alu #(.DATA_W(DATA_W), .ISOLATE(ISOLATE)) u_alu (
    .opSel    (opSel),
    .carryIn  (carryIn),
    .opA      (rdA),
    .opB      (rdB),
    .result   (yBus),
    .carryOut (aluCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      carryFlag <= 1'b0;
    end else begin
      if (strobe.pcAdvance) pc <= pc + PC_W'(1);
      if (strobe.flagWrite) carryFlag <= aluCarry;
    end
  end

  // R5: one step per executed cycle, modulo 2^PC_W.
  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.pcAdvance |=> pc == $past(pc) + PC_W'(1));

  // R6: a load cycle freezes the counter and the status bit.
  p_load_hold_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.rfFromLoad |=> $stable(pc) && $stable(carryFlag));

  // R3: logic operations leave the status bit clear.
  p_logic_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.flagWrite && (opSel == OP_AND || opSel == OP_OR || opSel == OP_NOT))
      |=> !carryFlag);

  // R2: ripple sum matches the arithmetic sum of the read operands.
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_ADD) |->
      {aluCarry, yBus} == ({1'b0, rdA} + {1'b0, rdB} + (DATA_W+1)'(carryIn)));

  // R2 / R3: subtraction difference and borrow-free carry.
  p_sub_diff_r2: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_SUB) |-> (yBus == DATA_W'(rdA - rdB)) && (aluCarry == (rdA >= rdB)));

  // R4: reserved codes give zero result and clear the flag.
  p_undef_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.flagWrite && opSel > OP_SUB) |-> yBus == '0 ##1 !carryFlag);

endmodule

// File: rtl/reg3_exec.sv
module reg3_exec
  import regdp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int PC_W    = 8,
  parameter bit ISOLATE = 1'b1,
  localparam int INSTR_W = OP_W + 1 + 3 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [DATA_W-1:0]  loadData,
  input  logic [INSTR_W-1:0] instr,
  output logic [PC_W-1:0]    pc,
  output logic               carryFlag,
  output logic [DATA_W-1:0]  yBus
);

  aluOp_e            opSel;
  logic              carryIn;
  logic [ADDR_W-1:0] srcA, srcB, dst;
  ctrlStrobe_t       strobe;

  regdp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .instr   (instr),
    .loadEn  (loadEn),
    .opSel   (opSel),
    .carryIn (carryIn),
    .srcA    (srcA),
    .srcB    (srcB),
    .dst     (dst),
    .strobe  (strobe)
  );

  regdp_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PC_W   (PC_W),
    .ISOLATE(ISOLATE)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .opSel     (opSel),
    .carryIn   (carryIn),
    .srcA      (srcA),
    .srcB      (srcB),
    .dst       (dst),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .pc        (pc),
    .carryFlag (carryFlag),
    .yBus      (yBus)
  );

endmodule

// File: tb/sim_reg3_exec.sv
`timescale 1ns/1ps
module sim_reg3_exec;

  logic        clk = 1'b0;
  logic        rst;
  logic        loadEn;
  logic [4:0]  loadAddr;
  logic [7:0]  loadData;
  logic [18:0] instr;
  logic [7:0]  pc;
  logic        carryFlag;
  logic [7:0]  yBus;

  always #5 clk = ~clk;

  reg3_exec u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .instr(instr), .pc(pc), .carryFlag(carryFlag), .yBus(yBus)
  );

  logic [7:0] model [32];
  logic [7:0] mPc;
  logic       mFlag;
  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  function automatic logic [8:0] refAlu(input logic [2:0] op, input logic c,
                                        input logic [7:0] a, input logic [7:0] b);
    case (op)
      3'd0: return {1'b0, a & b};
      3'd1: return {1'b0, a | b};
      3'd2: return {1'b0, ~a};
      3'd3: return {1'b0, a} + {1'b0, b} + {8'd0, c};
      3'd4: return {1'b0, a} + {1'b0, ~b} + 9'd1;
      default: return 9'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; loadEn = 1'b0; instr = '0;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    mPc = 8'h00; mFlag = 1'b0;
    check("R8", "pc after reset", pc, 0);
    check("R8", "carryFlag after reset", carryFlag, 0);
  endtask

  task automatic exec(input logic [2:0] op, input logic c, input logic [4:0] a,
                      input logic [4:0] b, input logic [4:0] d, input string req);
    logic [8:0] r;
    @(negedge clk);
    loadEn = 1'b0;
    instr  = {op, c, a, b, d};
    #1;
    r = refAlu(op, c, model[a], model[b]);
    check(req, "yBus", yBus, r[7:0]);
    @(posedge clk); #1;
    model[d] = r[7:0];
    mFlag    = r[8];
    mPc      = mPc + 8'd1;
    check("R3", "carryFlag", carryFlag, mFlag);
    check("R5", "pc", pc, mPc);
  endtask

  task automatic peek(input logic [4:0] k, input string req);
    exec(3'd1, 1'b0, k, k, k, req);
  endtask

  task automatic load(input logic [4:0] addr, input logic [7:0] data,
                      input logic [18:0] during);
    logic [8:0] r;
    @(negedge clk);
    loadEn = 1'b1; loadAddr = addr; loadData = data; instr = during;
    #1;
    r = refAlu(during[18:16], during[15], model[during[14:10]], model[during[9:5]]);
    check("R7", "yBus during load", yBus, r[7:0]);
    @(posedge clk); #1;
    model[addr] = data;
    check("R6", "pc held by load", pc, mPc);
    check("R6", "carryFlag held by load", carryFlag, mFlag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R5 watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; loadEn = 1'b0; loadAddr = '0; loadData = '0; instr = '0;
    doReset();
    for (int k = 0; k < 32; k++) peek(5'(k), "R8");

    // Preload all registers; an ADD into r31 sits on the bus meanwhile.
    for (int k = 0; k < 32; k++)
      load(5'(k), 8'($urandom), {3'd3, 1'b1, 5'(k), 5'd2, 5'd31});
    peek(5'd31, "R6");

    // Load r3 with NOT r3 -> r7 pending: r7 must not change, r3 takes new data.
    load(5'd3, 8'hA5, {3'd2, 1'b0, 5'd3, 5'd0, 5'd7});
    peek(5'd7, "R6");
    peek(5'd3, "R7");
    check("R6", "loaded r3", model[3], 8'hA5);

    // Carry-chain corners.
    load(5'd1, 8'hFF, 19'd0);
    load(5'd2, 8'h01, 19'd0);
    exec(3'd3, 1'b0, 5'd1, 5'd2, 5'd4, "R2");  // 0xFF+1 -> 0, carry 1
    check("R3", "add wrap carry", carryFlag, 1);
    exec(3'd3, 1'b1, 5'd2, 5'd2, 5'd5, "R2");  // 1+1+1 = 3
    peek(5'd5, "R2");
    exec(3'd4, 1'b0, 5'd2, 5'd1, 5'd6, "R2");  // 1-255 = 2, carry 0
    check("R3", "sub borrow", carryFlag, 0);
    exec(3'd4, 1'b0, 5'd1, 5'd1, 5'd6, "R2");  // cin ignored: 0, carry 1
    check("R3", "sub equal", carryFlag, 1);

    // Reserved codes after the flag was set.
    exec(3'd5, 1'b1, 5'd1, 5'd1, 5'd8, "R4");
    check("R4", "flag cleared by code 5", carryFlag, 0);
    exec(3'd3, 1'b0, 5'd1, 5'd2, 5'd9, "R2");
    exec(3'd6, 1'b0, 5'd1, 5'd2, 5'd9, "R4");
    peek(5'd9, "R4");
    exec(3'd3, 1'b0, 5'd1, 5'd2, 5'd10, "R2");
    exec(3'd7, 1'b1, 5'd3, 5'd1, 5'd10, "R4");
    check("R4", "flag cleared by code 7", carryFlag, 0);
    peek(5'd10, "R4");

    // Field positions with distinct addresses.
    load(5'd12, 8'h3C, 19'd0);
    load(5'd13, 8'h0F, 19'd0);
    exec(3'd0, 1'b0, 5'd12, 5'd13, 5'd14, "R1");
    peek(5'd14, "R1");
    exec(3'd1, 1'b0, 5'd13, 5'd12, 5'd15, "R1");
    peek(5'd15, "R1");
    exec(3'd3, 1'b1, 5'd12, 5'd13, 5'd16, "R1");
    peek(5'd16, "R1");

    // Destination equals source: read sees the old value.
    exec(3'd3, 1'b0, 5'd12, 5'd12, 5'd12, "R7");
    peek(5'd12, "R7");

    // Random mix.
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 8 == 0)
        load(5'($urandom), 8'($urandom), 19'($urandom));
      else
        exec(3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), "R2");
    end

    // Program counter wrap.
    while (mPc != 8'hFF)
      exec(3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), "R2");
    exec(3'd1, 1'b0, 5'd0, 5'd0, 5'd0, "R2");
    check("R5", "pc wrap to zero", pc, 0);

    // Reset in the middle of a run with the flag set.
    load(5'd20, 8'hF0, 19'd0);
    exec(3'd3, 1'b0, 5'd20, 5'd20, 5'd21, "R2");
    check("R3", "flag before reset", carryFlag, 1);
    doReset();
    for (int k = 0; k < 32; k++) peek(5'(k), "R8");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule